// File: doc/BRIEF.md
# Expansion Memory Map Controller

This block sits on an 8-bit processor bus with a 16-bit memory address and an 8-bit I/O port space. It steers every memory access to one of three places: an 8 kB boot ROM outside the block, an expansion RAM inside it, or a 1 kB base RAM, also inside it. Two I/O control bits choose the region that answers in each address window. The lowest 8 kB has its own select. The window from 0x2000 to 0x7FFF follows the expansion enable. While the expansion RAM is off, the base RAM shows up mirrored in 0x6000–0x7FFF.

The block also passes register traffic to an external sound generator. It holds a 4-bit register index and raises a write strobe or a read strobe toward that chip. Memory and I/O reads return their byte on `rdData` one clock after the read strobe is sampled. Writes take effect on the same clock edge. The expansion array has 2^EXP_AW bytes and is indexed by the low EXP_AW address bits. EXP_AW = 15 gives the full 32 kB; the default is smaller to keep elaboration light.

Top module: `exp_map_ctrl`

## Requirements
- R1: After reset the low 8 kB shows the ROM, the expansion RAM is off, the sound index is 0 and `rdData` is 0xFF.
- R2: A memory read in 0x0000–0x1FFF while the ROM is selected raises `romCs` in that cycle, drives `romAddr` = addr[12:0], and returns `romData` on `rdData` in the next cycle.
- R3: An I/O write to port 0x7F with data bit 1 = 0 maps expansion RAM (offset = low EXP_AW address bits) into 0x0000–0x1FFF. Bit 1 = 1 maps the ROM back.
- R4: An I/O write to port 0x53 with data bit 0 = 1 maps expansion RAM into 0x2000–0x7FFF for reads and writes. Bit 0 = 0 unmaps it. The array is shared with the low-area view at the same offset.
- R5: The port 0x53 enable has no effect on 0x0000–0x1FFF.
- R6: While expansion RAM is off, 0x6000–0x7FFF reads and writes the base RAM at addr[9:0], so the base RAM appears mirrored eight times.
- R7: While expansion RAM is off, 0x2000–0x5FFF reads 0xFF and ignores writes. Any address at or above 0x8000 always reads 0xFF and ignores writes.
- R8: Writes to 0x0000–0x1FFF are dropped while the ROM is selected.
- R9: An I/O write to port 0x50 stores data[3:0] as `sndIdx`. An I/O write to port 0x51 pulses `sndWr` in that cycle.
- R10: An I/O read of port 0x52 pulses `sndRd` in that cycle and returns `sndRdData` on `rdData` in the next cycle.
- R11: I/O reads of any other port return 0xFF. I/O writes to unlisted ports change no state.
- R12: Only addr[7:0] is compared when decoding I/O ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memRd | input | 1 | Memory read strobe |
| memWr | input | 1 | Memory write strobe |
| ioRd | input | 1 | I/O read strobe |
| ioWr | input | 1 | I/O write strobe |
| addr | input | 16 | Memory address, or I/O port in bits 7:0 |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, one cycle after the read strobe |
| romCs | output | 1 | Boot ROM select |
| romAddr | output | 13 | Boot ROM address |
| romData | input | 8 | Boot ROM data, valid in the cycle `romCs` is high |
| sndIdx | output | 4 | Sound generator register index |
| sndWr | output | 1 | Sound register write strobe |
| sndRd | output | 1 | Sound register read strobe |
| sndRdData | input | 8 | Sound register read value |

## Verification
The bench targets the opposite polarity of the two control bits. A design that inverted the port 0x7F bit would start with RAM in the boot area and return garbage on the first ROM fetch. It also checks that the expansion enable leaves the low 8 kB alone, which a decoder that tested only address bit 15 would break. Base RAM is read back through a mirror address, so an address translation that used more than ten bits would miss the stored byte. I/O writes go to ports with non-zero upper address bits and to the read-only sound port; a decoder that compared all sixteen bits, or that accepted writes at port 0x52, would leave state wrong and the following reads would show it.

// File: rtl/exp_map_pkg.sv
package exp_map_pkg;
  localparam logic [7:0] PORT_SND_IDX = 8'h50;
  localparam logic [7:0] PORT_SND_WR  = 8'h51;
  localparam logic [7:0] PORT_SND_RD  = 8'h52;
  localparam logic [7:0] PORT_EXP_EN  = 8'h53;
  localparam logic [7:0] PORT_LOW_SEL = 8'h7F;

  typedef enum logic [2:0] {
    SRC_FF, SRC_ROM, SRC_EXP, SRC_BASE, SRC_SND
  } rdSrc_e;

  typedef struct packed {
    logic   rdEn;
    rdSrc_e src;
    logic   expWe;
    logic   baseWe;
  } dpStrobes_t;
endpackage

// File: rtl/exp_map_ctrl_unit.sv
module exp_map_ctrl_unit
  import exp_map_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        memRd,
  input  logic        memWr,
  input  logic        ioRd,
  input  logic        ioWr,
  input  logic [15:0] addr,
  input  logic [7:0]  wrData,
  output dpStrobes_t  strb,
  output logic        romCs,
  output logic [12:0] romAddr,
  output logic [3:0]  sndIdx,
  output logic        sndWr,
  output logic        sndRd
);
  logic lowRamSel;
  logic expRamEn;
  logic [7:0] port;
  logic lowArea, midArea, baseArea;

  assign port     = addr[7:0];
  assign lowArea  = (addr[15:13] == 3'b000);
  assign midArea  = !addr[15] && !lowArea;
  assign baseArea = (addr[15:13] == 3'b011);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowRamSel <= 1'b0;
      expRamEn  <= 1'b0;
      sndIdx    <= '0;
    end else if (ioWr) begin
      case (port)
        PORT_SND_IDX: sndIdx    <= wrData[3:0];
        PORT_EXP_EN:  expRamEn  <= wrData[0];
        PORT_LOW_SEL: lowRamSel <= !wrData[1];
        default: ;
      endcase
    end
  end

  rdSrc_e memSrc;
  always_comb begin
    memSrc = SRC_FF;
    if (lowArea)
      memSrc = lowRamSel ? SRC_EXP : SRC_ROM;
    else if (midArea) begin
      if (expRamEn)      memSrc = SRC_EXP;
      else if (baseArea) memSrc = SRC_BASE;
    end
  end

  always_comb begin
    strb.rdEn   = memRd || ioRd;
    strb.src    = memRd ? memSrc : ((port == PORT_SND_RD) ? SRC_SND : SRC_FF);
    strb.expWe  = memWr && (memSrc == SRC_EXP);
    strb.baseWe = memWr && (memSrc == SRC_BASE);
  end

  assign romCs   = memRd && (memSrc == SRC_ROM);
  assign romAddr = addr[12:0];
  assign sndWr   = ioWr && (port == PORT_SND_WR);
  assign sndRd   = ioRd && !memRd && (port == PORT_SND_RD);
endmodule

// File: rtl/exp_map_datapath.sv
module exp_map_datapath
  import exp_map_pkg::*;
#(
  parameter int EXP_AW  = 12,
  parameter int BASE_AW = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobes_t  strb,
  input  logic [15:0] addr,
  input  logic [7:0]  wrData,
  input  logic [7:0]  romData,
  input  logic [7:0]  sndRdData,
  output logic [7:0]  rdData
);
  localparam int EXP_DEPTH  = 1 << EXP_AW;
  localparam int BASE_DEPTH = 1 << BASE_AW;

  logic [7:0] expRam  [EXP_DEPTH];
  logic [7:0] baseRam [BASE_DEPTH];
  logic [EXP_AW-1:0]  expIdx;
  logic [BASE_AW-1:0] baseIdx;

  assign expIdx  = addr[EXP_AW-1:0];
  assign baseIdx = addr[BASE_AW-1:0];

  always_ff @(posedge clk) begin
    if (strb.expWe)  expRam[expIdx]   <= wrData;
    if (strb.baseWe) baseRam[baseIdx] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= 8'hFF;
    else if (strb.rdEn) begin
      case (strb.src)
        SRC_ROM:  rdData <= romData;
        SRC_EXP:  rdData <= expRam[expIdx];
        SRC_BASE: rdData <= baseRam[baseIdx];
        SRC_SND:  rdData <= sndRdData;
        default:  rdData <= 8'hFF;
      endcase
    end
  end
endmodule

// File: rtl/exp_map_ctrl.sv
module exp_map_ctrl
  import exp_map_pkg::*;
#(
  parameter int EXP_AW  = 12,
  parameter int BASE_AW = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        memRd,
  input  logic        memWr,
  input  logic        ioRd,
  input  logic        ioWr,
  input  logic [15:0] addr,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  output logic        romCs,
  output logic [12:0] romAddr,
  input  logic [7:0]  romData,
  output logic [3:0]  sndIdx,
  output logic        sndWr,
  output logic        sndRd,
  input  logic [7:0]  sndRdData
);
  dpStrobes_t strb;

  exp_map_ctrl_unit ctrl_i (
    .clk(clk), .rstN(rstN), .memRd(memRd), .memWr(memWr),
    .ioRd(ioRd), .ioWr(ioWr), .addr(addr), .wrData(wrData),
    .strb(strb), .romCs(romCs), .romAddr(romAddr),
    .sndIdx(sndIdx), .sndWr(sndWr), .sndRd(sndRd)
  );

  exp_map_datapath #(.EXP_AW(EXP_AW), .BASE_AW(BASE_AW)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .wrData(wrData),
    .romData(romData), .sndRdData(sndRdData), .rdData(rdData)
  );
endmodule

// File: rtl/exp_map_chk.sv
module exp_map_chk (
  input logic        clk,
  input logic        rstN,
  input logic        memRd,
  input logic        ioRd,
  input logic        ioWr,
  input logic [15:0] addr,
  input logic [7:0]  wrData,
  input logic [7:0]  rdData,
  input logic        romCs,
  input logic [3:0]  sndIdx,
  input logic        sndWr,
  input logic        sndRd
);
  assert_rom_cs_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    romCs |-> (memRd && addr[15:13] == 3'b000));

  assert_high_reads_ff_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && addr[15]) |=> (rdData == 8'hFF));

  assert_idx_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ioWr && addr[7:0] == 8'h50) |=> (sndIdx == $past(wrData[3:0])));

  assert_idx_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(ioWr && addr[7:0] == 8'h50) |=> $stable(sndIdx));

  assert_snd_wr_port_R9: assert property (@(posedge clk) disable iff (!rstN)
    sndWr |-> (ioWr && addr[7:0] == 8'h51));

  assert_snd_rd_port_R10: assert property (@(posedge clk) disable iff (!rstN)
    sndRd |-> (ioRd && addr[7:0] == 8'h52));

  assert_other_io_ff_R11: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && !memRd && addr[7:0] != 8'h52) |=> (rdData == 8'hFF));
endmodule

bind exp_map_ctrl exp_map_chk chk_i (
  .clk(clk), .rstN(rstN), .memRd(memRd), .ioRd(ioRd), .ioWr(ioWr),
  .addr(addr), .wrData(wrData), .rdData(rdData), .romCs(romCs),
  .sndIdx(sndIdx), .sndWr(sndWr), .sndRd(sndRd)
);

// File: tb/exp_map_ctrl_tb.sv
module exp_map_ctrl_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic memRd = 0, memWr = 0, ioRd = 0, ioWr = 0;
  logic [15:0] addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData, romData, sndRdData;
  logic        romCs, sndWr, sndRd;
  logic [12:0] romAddr;
  logic [3:0]  sndIdx;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #2 clk = !clk;

  // ROM and sound chip models
  assign romData   = romCs ? (romAddr[7:0] ^ 8'hA5) : 8'h00;
  assign sndRdData = {4'hC, sndIdx};

  exp_map_ctrl dut_i (
    .clk(clk), .rstN(rstN), .memRd(memRd), .memWr(memWr), .ioRd(ioRd),
    .ioWr(ioWr), .addr(addr), .wrData(wrData), .rdData(rdData),
    .romCs(romCs), .romAddr(romAddr), .romData(romData), .sndIdx(sndIdx),
    .sndWr(sndWr), .sndRd(sndRd), .sndRdData(sndRdData)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // op: 0 memWr, 1 memRd, 2 ioWr, 3 ioRd
  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] a;
    logic [7:0]  d;
    logic [7:0]  e;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 16'h0100, 8'h00, 8'hA5, 8'd2},  // R2 ROM fetch
    '{2'd0, 16'h0100, 8'h11, 8'h00, 8'd8},
    '{2'd1, 16'h0100, 8'h00, 8'hA5, 8'd8},  // R8 write dropped
    '{2'd0, 16'h6005, 8'h5A, 8'h00, 8'd6},
    '{2'd1, 16'h7C05, 8'h00, 8'h5A, 8'd6},  // R6 mirror
    '{2'd1, 16'h2345, 8'h00, 8'hFF, 8'd7},  // R7 hole
    '{2'd0, 16'h2345, 8'h77, 8'h00, 8'd7},
    '{2'd1, 16'h9000, 8'h00, 8'hFF, 8'd7},  // R7 high
    '{2'd2, 16'h0053, 8'h01, 8'h00, 8'd4},
    '{2'd0, 16'h2345, 8'h33, 8'h00, 8'd4},
    '{2'd1, 16'h2345, 8'h00, 8'h33, 8'd4},  // R4 enabled
    '{2'd1, 16'h0100, 8'h00, 8'hA5, 8'd5},  // R5 low area unaffected
    '{2'd2, 16'h007F, 8'h00, 8'h00, 8'd3},
    '{2'd0, 16'h0100, 8'h44, 8'h00, 8'd3},
    '{2'd1, 16'h0100, 8'h00, 8'h44, 8'd3},  // R3 RAM in low area
    '{2'd1, 16'h2100, 8'h00, 8'h44, 8'd4},  // R4 shared offset
    '{2'd2, 16'h007F, 8'h02, 8'h00, 8'd3},
    '{2'd1, 16'h0100, 8'h00, 8'hA5, 8'd3},  // R3 ROM back
    '{2'd2, 16'h0053, 8'h00, 8'h00, 8'd4},
    '{2'd1, 16'h6005, 8'h00, 8'h5A, 8'd6},  // R6 retained
    '{2'd1, 16'h2345, 8'h00, 8'hFF, 8'd7},  // R7 disabled again
    '{2'd2, 16'h1253, 8'h01, 8'h00, 8'd12},
    '{2'd1, 16'h2345, 8'h00, 8'h33, 8'd12}, // R12 high port byte ignored
    '{2'd3, 16'h0040, 8'h00, 8'hFF, 8'd11}, // R11 other port
    '{2'd2, 16'h0052, 8'hFF, 8'h00, 8'd11},
    '{2'd3, 16'h0052, 8'h00, 8'hC0, 8'd10}, // R10 / R11 index still 0
    '{2'd2, 16'h0050, 8'hF9, 8'h00, 8'd9},
    '{2'd3, 16'hAB52, 8'h00, 8'hC9, 8'd9},  // R9 index 9, R12
    '{2'd1, 16'hFFFF, 8'h00, 8'hFF, 8'd7}   // R7 top
  };

  task automatic doOp(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d;
    memWr = (op == 2'd0); memRd = (op == 2'd1);
    ioWr = (op == 2'd2);  ioRd = (op == 2'd3);
    @(negedge clk);
    memWr = 0; memRd = 0; ioWr = 0; ioRd = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check({8'h0, rdData}, 16'h00FF, "R1 rdData");
    check({12'h0, sndIdx}, 16'h0, "R1 sndIdx");
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      doOp(VECS[i].op, VECS[i].a, VECS[i].d);
      if (VECS[i].op[0])
        check({8'h0, rdData}, {8'h0, VECS[i].e}, $sformatf("R%0d vec%0d", VECS[i].req, i));
    end

    // R2 ROM select and address during the read cycle
    @(negedge clk);
    addr = 16'h1ABC; memRd = 1; #1;
    check({15'h0, romCs}, 16'h1, "R2 romCs");
    check({3'h0, romAddr}, 16'h1ABC, "R2 romAddr");
    @(negedge clk); memRd = 0;
    check({8'h0, rdData}, 16'h0019, "R2 rdData");
    // R9 write strobe
    @(negedge clk);
    addr = 16'h0051; wrData = 8'h3C; ioWr = 1; #1;
    check({15'h0, sndWr}, 16'h1, "R9 sndWr");
    @(negedge clk); ioWr = 0;
    // R10 read strobe
    addr = 16'h0052; ioRd = 1; #1;
    check({15'h0, sndRd}, 16'h1, "R10 sndRd");
    @(negedge clk); ioRd = 0;
    // R11 write to unlisted port keeps mapping and index
    doOp(2'd2, 16'h0054, 8'h00);
    doOp(2'd1, 16'h0100, 8'h00);
    check({8'h0, rdData}, 16'h00A5, "R11 map kept");
    check({12'h0, sndIdx}, 16'h9, "R11 idx kept");
    // R1 reset mid-run restores ROM and index
    doOp(2'd2, 16'h007F, 8'h00);
    doOp(2'd2, 16'h0050, 8'h05);
    @(negedge clk); rstN = 0;
    @(negedge clk);
    check({8'h0, rdData}, 16'h00FF, "R1 rdData after reset");
    check({12'h0, sndIdx}, 16'h0, "R1 sndIdx after reset");
    rstN = 1;
    doOp(2'd1, 16'h0100, 8'h00);
    check({8'h0, rdData}, 16'h00A5, "R1 ROM after reset");
    doOp(2'd1, 16'h2345, 8'h00);
    check({8'h0, rdData}, 16'h00FF, "R1 expansion off after reset");

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule